// File: doc/BRIEF.md
# Prescaled Request Wait Time-out Counter

This block measures how long a DMA channel has been stalled waiting for a peripheral request, and reports a time-out when that wait lasts for a programmed number of slow ticks. It has two timing stages in a chain. The first stage divides the system clock by 2^(8+N), where N is a 3-bit select. The second stage counts those slow ticks against a 16-bit period value.

Time is counted only while the block is enabled and the channel is waiting with no request arriving. Any request strobe, a drop of the waiting indicator or a cleared enable returns both stages to zero. Once a time-out fires, both stages halt until the next restart, so one wait produces exactly one event. The sticky flag is cleared by a write-1 strobe.

Top module: `wait_timeout_timer`

## Requirements
- R1: The tick stage divides the clock by 2^(8+psc_sel_i), where psc_sel_i is an unsigned 3-bit value: 256 for 0 and 32768 for 7.
- R2: After period_i*2^(8+psc_sel_i) consecutive clock cycles of counting (enable_i=1, waiting_i=1, req_i=0), event_o is high for exactly one cycle. The pulse starts on the clock edge that ends the last of those cycles.
- R3: While enable_i is 0, nothing is counted and both stages return to zero. A later wait starts timing from zero again.
- R4: A cycle with req_i=1 returns both stages to zero and produces no event on the following edge.
- R5: A cycle with waiting_i=0 returns both stages to zero and produces no event on the following edge.
- R6: After a time-out the counters hold, and no further event occurs until a restart (R3, R4 or R5).
- R7: A period_i of 0 never produces an event.
- R8: flag_o is set on the same edge as event_o and stays set until a cycle with flag_clr_i=1. If a time-out and a clear arrive in the same cycle, the set takes priority.
- R9: While rst_ni is low, flag_o and event_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Time-out counting enable |
| waiting_i | input | 1 | Channel is waiting for a peripheral request |
| req_i | input | 1 | Peripheral request strobe |
| period_i | input | 16 | Time-out period in prescaled ticks; 0 never expires |
| psc_sel_i | input | 3 | Prescaler select N, divide 2^(8+N) |
| flag_clr_i | input | 1 | Write-1 clear of the time-out flag |
| flag_o | output | 1 | Sticky time-out flag |
| event_o | output | 1 | One-cycle time-out event pulse |

## Verification
The hardest case to reach from the ports is the widest divide (select 7): it needs more than 32000 uninterrupted waiting cycles before a single event appears. The bench holds the waiting inputs steady for that long, and it also runs multi-tick periods at smaller divides. Restarts are placed just before the expected expiry, so a stage that fails to clear would fire early. A clear strobe held across the firing cycle exercises the priority between set and clear.

// File: rtl/wtt_pkg.sv
package wtt_pkg;
  localparam int unsigned BASE_SHIFT = 8;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned PERIOD_W   = 16;

  function automatic int unsigned pre_width(int unsigned base, int unsigned sel_w);
    return base + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/wtt_prescaler.sv
module wtt_prescaler #(
  parameter int unsigned BASE_SHIFT = wtt_pkg::BASE_SHIFT,
  parameter int unsigned SEL_W      = wtt_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = wtt_pkg::pre_width(BASE_SHIFT, SEL_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   one_sh;
  logic [CNT_W-1:0] term;

  always_comb begin
    one_sh = (CNT_W+1)'(1) << (BASE_SHIFT + 32'(sel_i));
    term   = CNT_W'(one_sh - 1'b1);
  end

  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || tick_o)  cnt_q <= '0;
    else if (run_i)              cnt_q <= cnt_q + 1'b1;
  end

  // R4: restart empties the divider
  p_clear_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
  // R1: a tick wraps the divider
  p_tick_wraps_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/wtt_period.sv
module wtt_period #(
  parameter int unsigned PERIOD_W = wtt_pkg::PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                fire_o,
  output logic                expired_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                expired_q;
  logic [PERIOD_W-1:0] cnt_nxt;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign fire_o    = tick_i && !expired_q && (period_i != '0) && (cnt_nxt == period_i);
  assign expired_o = expired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (fire_o) begin
      expired_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R7: zero period never fires
  p_zero_never_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> !fire_o);
  // R6: expiry holds until restart
  p_hold_expired_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && !clear_i) |=> expired_q);
endmodule

// File: rtl/wtt_flag.sv
module wtt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic event_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      event_o <= 1'b0;
    end else begin
      event_o <= fire_i;
      if (fire_i)     flag_o <= 1'b1;   // set beats clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  p_clear_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fire_i) |=> !flag_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_o);
endmodule

// File: rtl/wait_timeout_timer.sv
module wait_timeout_timer #(
  parameter int unsigned BASE_SHIFT = wtt_pkg::BASE_SHIFT,
  parameter int unsigned SEL_W      = wtt_pkg::SEL_W,
  parameter int unsigned PERIOD_W   = wtt_pkg::PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                waiting_i,
  input  logic                req_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [SEL_W-1:0]    psc_sel_i,
  input  logic                flag_clr_i,
  output logic                flag_o,
  output logic                event_o
);
  logic restart, run, tick, fire, expired;

  assign restart = req_i || !waiting_i || !enable_i;
  assign run     = !restart && !expired;

  wtt_prescaler #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(restart),
    .run_i  (run),
    .sel_i  (psc_sel_i),
    .tick_o (tick)
  );

  wtt_period #(.PERIOD_W(PERIOD_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart),
    .tick_i   (tick),
    .period_i (period_i),
    .fire_o   (fire),
    .expired_o(expired)
  );

  wtt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o),
    .event_o(event_o)
  );

  p_event_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
  p_event_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> flag_o);
  p_disable_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !event_o);
  p_req_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !event_o);
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !waiting_i |=> !event_o);
  p_expired_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired && !restart) |=> !event_o);
endmodule

// File: tb/wait_timeout_timer_tb_top.sv
module wait_timeout_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, waiting_i = 1'b0, req_i = 1'b0, flag_clr_i = 1'b0;
  logic [15:0] period_i = '0;
  logic [2:0]  psc_sel_i = '0;
  logic        flag_o, event_o;

  int     checks = 0, errors = 0, events = 0;
  string  tag = "R9";
  bit     finished = 1'b0;

  // reference model state
  longint elapsed = 0;
  bit     m_done = 0, m_ev = 0, m_flag = 0;

  always #10 clk_i = ~clk_i;

  wait_timeout_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .waiting_i(waiting_i),
    .req_i(req_i), .period_i(period_i), .psc_sel_i(psc_sel_i),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .event_o(event_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed = 0; m_done = 0; m_ev = 0; m_flag = 0;
    end else begin
      bit fire;
      fire = 0;
      if (!enable_i || !waiting_i || req_i) begin
        elapsed = 0; m_done = 0;
      end else if (!m_done && period_i != 0) begin
        elapsed++;
        if (elapsed == longint'(period_i) * (longint'(1) << (8 + psc_sel_i))) begin
          fire = 1; m_done = 1;
        end
      end
      m_ev = fire;
      if (fire) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
    end
  end

  always @(negedge clk_i) begin
    checks++;
    if (event_o !== m_ev || flag_o !== m_flag) begin
      errors++;
      $display("FAIL %s: event_o=%b flag_o=%b expected event_o=%b flag_o=%b",
               tag, event_o, flag_o, m_ev, m_flag);
    end
    if (event_o === 1'b1) events++;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_events(input int exp);
    checks++;
    if (events != exp) begin
      errors++;
      $display("FAIL %s: events=%0d expected %0d", tag, events, exp);
    end
    events = 0;
  endtask

  task automatic setup(input int p, input int s);
    waiting_i = 1'b0; period_i = 16'(p); psc_sel_i = 3'(s);
    @(negedge clk_i);
    events = 0;
    waiting_i = 1'b1;
  endtask

  initial begin
    // R9: reset state
    tag = "R9";
    run(4);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    // R1 / R2: smallest divide, period 1 -> event after 256 cycles
    tag = "R2"; setup(1, 0); run(300); expect_events(1);
    // R1: divide 1024, period 2 -> 2048 cycles
    tag = "R1"; setup(2, 2); run(2100); expect_events(1);
    // R6: hold, no second event
    tag = "R6"; run(3000); expect_events(0);
    // R8: clear flag
    tag = "R8"; flag_clr_i = 1'b1; run(1); flag_clr_i = 1'b0; run(3);
    // R4: request just before expiry (period 2, divide 256 -> 512)
    tag = "R4"; setup(2, 0); run(500); req_i = 1'b1; run(1); req_i = 1'b0;
    run(500); expect_events(0); run(20); expect_events(1);
    // R5: wait drop just before expiry
    tag = "R5"; setup(2, 0); run(500); waiting_i = 1'b0; run(1); waiting_i = 1'b1;
    run(500); expect_events(0); run(20); expect_events(1);
    // R3: disable for a long time while waiting, then short drop before expiry
    tag = "R3"; setup(1, 0); enable_i = 1'b0; run(1000); expect_events(0);
    enable_i = 1'b1; run(250); enable_i = 1'b0; run(2); enable_i = 1'b1;
    run(250); expect_events(0); run(20); expect_events(1);
    // R7: period zero never expires
    tag = "R7"; setup(0, 0); run(3000); expect_events(0);
    // R8: clear held through the firing cycle, set wins
    tag = "R8"; flag_clr_i = 1'b1; setup(1, 0); run(300); expect_events(1);
    flag_clr_i = 1'b0; run(2);
    // R1: widest divide 32768
    tag = "R1"; setup(1, 7); run(32700); expect_events(0); run(100); expect_events(1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog %s: run did not end, expected completion", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule